// File: doc/BRIEF.md
# Externally synchronized frame-sync generator

This block drives two timing channels. Each channel produces a divided clock and a frame-sync pulse train from the system clock. Software sets the divisors, the pulse width, the starting phase and a reference source through a write-only register port. The outputs then start when their enables are set.

In sync mode an output waits, after its enable, for a rising edge on a chosen external reference. That edge passes through a two-flop synchronizer and a registered edge detector. The frame-sync counter is preloaded with the phase value at start, so a phase of 3 cancels the three cycles of detector latency. With a reference whose period equals the frame divisor, the frame-sync rises in the same system-clock cycle in which the reference is first sampled high. Once started, an output runs freely from its own divider. Clearing its enable forces it low at once and arms the edge wait again.

Top module: `xsync_fsgen`

## Requirements
- R1: During reset and after its release, with nothing enabled, every bit of `sclk_o` and `fsync_o` is 0.
- R2: With clock sync off, a clock output whose enable is written at edge T starts at edge T+1. After edge T+1+k it is high when (k mod E) < E/2 (integer division), where E is the clock divisor, or 2 if the divisor is below 2. The clock divisor sits in bits [7:0] of address 2 (channel 0) or address 4 (channel 1).
- R3: With frame sync off, a frame-sync output whose enable is written at edge T starts at edge T+1. After edge T+1+k it is high when ((P+k) mod F) < W. F is the frame divisor, in bits [23:16] of address 2/4. W is the width and P the phase (P < F), in bits [7:0] and [23:16] of address 3 (channel 0) or address 5 (channel 1).
- R4: Frame-sync sync mode is set by bit 0 (channel 0) or bit 16 (channel 1) of address 1. In this mode the output stays low until the selected reference is sampled high after being low. If that sample is edge E, then after edge E+m the output is low for m < 3, and for m >= 3 it is high when ((P+m-3) mod F) < W.
- R5: Clock sync mode is set by bit 1 (channel 0) or bit 17 (channel 1) of address 1. In this mode the clock output stays low until a reference edge is sampled at edge E. For m >= 3 it is then high when ((m-3) mod E) < E/2.
- R6: The reference is `ref_i[sel]`. The select field is bits [1:0] (channel 0) or [17:16] (channel 1) of address 6. Activity on unselected sources has no effect.
- R7: In frame-sync sync mode with P=3 and a reference of period F, from m >= 3 the frame-sync output equals the reference value sampled at the same edge.
- R8: Once started, an output ignores later reference edges and keeps counting freely.
- R9: Writing 0 to an enable bit forces that output low from the write edge on. A later enable waits for a fresh reference edge in sync mode, even if the write coincides with the start edge.
- R10: Writes to addresses 1–6 are ignored for a channel while either of its enables is set. Each channel's fields are judged on their own.
- R11: Address 0 holds the enables: bit 0 frame-sync and bit 1 clock of channel 0, bit 16 frame-sync and bit 17 clock of channel 1. Enable writes are always accepted.
- R12: The two channels run independently with their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| ref_i | input | NSRC | Candidate external reference sources |
| sclk_o | output | 2 | Divided clock output per channel |
| fsync_o | output | 2 | Frame-sync output per channel |

## Verification
Two events can land on the same system-clock edge: an enable-clear write and the start that follows a detected reference edge. The bench raises the reference exactly three edges before the disable write, so the start condition and the disable are decided on one edge. The output must stay low. A re-enable while the reference stays high must also leave it low, and only a new low-to-high transition may start it, following the R4 timing from that edge.

// File: rtl/xsync_fsgen.sv
module xsync_fsgen #(
  parameter int DIV_W = 8,
  parameter int NSRC  = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic [NSRC-1:0]  ref_i,
  output logic [1:0]       sclk_o,
  output logic [1:0]       fsync_o
);

  logic unused_bits;
  assign unused_bits = ^wr_data_i;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int B = 16 * ch;
    localparam logic [2:0] A_DIV = 3'(2 + 2 * ch);
    localparam logic [2:0] A_FS  = 3'(3 + 2 * ch);

    logic             en_c, en_f, sy_c, sy_f;
    logic [DIV_W-1:0] cdiv, fdiv, fwid, fph;
    logic [SEL_W-1:0] sel;
    logic             s1, s2, s3, rise;
    logic             run_c, run_f;
    logic [DIV_W-1:0] cc, fc;
    logic [DIV_W-1:0] clast, chalf, flast;
    logic             cfg_ok;

    assign cfg_ok = wr_en_i & ~(en_c | en_f);
    assign clast  = (cdiv < DIV_W'(2)) ? DIV_W'(1) : cdiv - 1'b1;
    assign chalf  = (cdiv < DIV_W'(2)) ? DIV_W'(1) : (cdiv >> 1);
    assign flast  = (fdiv < DIV_W'(2)) ? DIV_W'(1) : fdiv - 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_c <= 1'b0; en_f <= 1'b0; sy_c <= 1'b0; sy_f <= 1'b0;
        cdiv <= '0; fdiv <= '0; fwid <= '0; fph <= '0; sel <= '0;
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; rise <= 1'b0;
        run_c <= 1'b0; run_f <= 1'b0; cc <= '0; fc <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == 3'd0) begin
          en_f <= wr_data_i[B];
          en_c <= wr_data_i[B+1];
        end
        if (cfg_ok && wr_addr_i == 3'd1) begin
          sy_f <= wr_data_i[B];
          sy_c <= wr_data_i[B+1];
        end
        if (cfg_ok && wr_addr_i == A_DIV) begin
          cdiv <= wr_data_i[DIV_W-1:0];
          fdiv <= wr_data_i[16 +: DIV_W];
        end
        if (cfg_ok && wr_addr_i == A_FS) begin
          fwid <= wr_data_i[DIV_W-1:0];
          fph  <= wr_data_i[16 +: DIV_W];
        end
        if (cfg_ok && wr_addr_i == 3'd6)
          sel <= wr_data_i[B +: SEL_W];

        s1   <= ref_i[sel];
        s2   <= s1;
        s3   <= s2;
        rise <= s2 & ~s3;

        if (!en_c) run_c <= 1'b0;
        else if (!run_c) begin
          if (!sy_c || rise) begin
            run_c <= 1'b1;
            cc    <= '0;
          end
        end else cc <= (cc >= clast) ? '0 : cc + 1'b1;

        if (!en_f) run_f <= 1'b0;
        else if (!run_f) begin
          if (!sy_f || rise) begin
            run_f <= 1'b1;
            fc    <= fph;
          end
        end else fc <= (fc >= flast) ? '0 : fc + 1'b1;
      end
    end

    assign sclk_o[ch]  = en_c & run_c & (cc < chalf);
    assign fsync_o[ch] = en_f & run_f & (fc < fwid);
  end

endmodule

// File: rtl/xsync_fsgen_chk.sv
module xsync_fsgen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic [1:0]  sclk_o,
  input logic [1:0]  fsync_o
);
  logic seen;
  always_ff @(posedge clk_i) seen <= 1'b1;

  always @(posedge clk_i) begin
    if (seen === 1'b1 && !rst_ni) begin
      // R1
      rst_quiet_chk: assert (sclk_o == 2'b00 && fsync_o == 2'b00);
    end
  end

  // R9
  fs0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && !wr_data_i[0]) |=> !fsync_o[0]);
  // R9
  clk0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && !wr_data_i[1]) |=> !sclk_o[0]);
  // R9
  fs1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && !wr_data_i[16]) |=> !fsync_o[1]);
  // R9
  clk1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && !wr_data_i[17]) |=> !sclk_o[1]);
endmodule

bind xsync_fsgen xsync_fsgen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .sclk_o(sclk_o), .fsync_o(fsync_o)
);

// File: tb/xsync_fsgen_test.sv
module xsync_fsgen_test;
  logic clk = 1'b0, rst_n = 1'b1, we = 1'b0;
  logic [2:0] wa = '0;
  logic [31:0] wd = '0;
  logic [3:0] ref_i = '0;
  logic [1:0] sclk, fsync;
  int total = 0, bad = 0;

  xsync_fsgen uut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa),
                   .wr_data_i(wd), .ref_i(ref_i), .sclk_o(sclk), .fsync_o(fsync));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; wa = a; wd = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic int fs_e(int p, int k, int f, int w);
    return (((p + k) % f) < w) ? 1 : 0;
  endfunction

  function automatic int ck_e(int c, int k);
    int e = (c < 2) ? 2 : c;
    return ((k % e) < (e / 2)) ? 1 : 0;
  endfunction

  // compares one output bit against expectation, remembering the first miss
  task automatic acc(input int act, input int exp, inout int err, inout int fa, inout int fe);
    if (act != exp && err == 0) begin fa = act; fe = exp; end
    if (act != exp) err++;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, a0, x0, e1, a1, x1, e2, a2, x2, e3, a3, x3, k;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk == 0 && fsync == 0, "R1 in reset", {sclk, fsync}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk == 0 && fsync == 0, "R1 after release", {sclk, fsync}, 0);

    // R2 R3 R11 R12: sweep of small divisors on both channels at once
    for (int f = 2; f <= 6; f++)
      for (int w = 0; w < f; w++)
        for (int p = 0; p < f; p++) begin
          wr(3'd2, (f << 16) | (f + w));
          wr(3'd3, (p << 16) | w);
          wr(3'd4, ((f + 1) << 16) | p);
          wr(3'd5, (w << 16) | p);
          wr(3'd0, 32'h0003_0003);
          e0 = 0; e1 = 0; e2 = 0; e3 = 0;
          a0 = 0; x0 = 0; a1 = 0; x1 = 0; a2 = 0; x2 = 0; a3 = 0; x3 = 0;
          for (int i = 0; i < 2 * f + 5; i++) begin
            @(negedge clk);
            acc(int'(sclk[0]), ck_e(f + w, i), e0, a0, x0);
            acc(int'(fsync[0]), fs_e(p, i, f, w), e1, a1, x1);
            acc(int'(sclk[1]), ck_e(p, i), e2, a2, x2);
            acc(int'(fsync[1]), fs_e(w, i, f + 1, p), e3, a3, x3);
          end
          chk(e0 == 0, "R2 ch0 clock", a0, x0);
          chk(e1 == 0, "R3 ch0 frame", a1, x1);
          chk(e2 == 0, "R12 ch1 clock", a2, x2);
          chk(e3 == 0, "R3 ch1 frame", a3, x3);
          wr(3'd0, 32'h0);
          chk(sclk == 0 && fsync == 0, "R9 disable", {sclk, fsync}, 0);
        end

    // R11: only the channel-0 frame-sync enable
    wr(3'd2, (4 << 16) | 4);
    wr(3'd3, 2);
    wr(3'd0, 32'h1);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc(int'(sclk[0]), 0, e0, a0, x0);
      acc(int'(fsync[0]), fs_e(0, i, 4, 2), e0, a0, x0);
    end
    chk(e0 == 0, "R11 enable bit layout", a0, x0);
    wr(3'd0, 32'h0);

    // R10: config writes while enabled are ignored; other channel still accepts
    wr(3'd1, 32'h0);
    wr(3'd2, (4 << 16) | 2);
    wr(3'd3, 1);
    wr(3'd0, 32'h3);
    wr(3'd2, (6 << 16) | 6);
    wr(3'd3, (2 << 16) | 5);
    wr(3'd1, 32'h3);
    wr(3'd6, 32'h1);
    wr(3'd4, (3 << 16) | 3);
    wr(3'd5, 1);
    wr(3'd0, 32'h0003_0003);
    e0 = 0; a0 = 0; x0 = 0; e1 = 0; a1 = 0; x1 = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      acc(int'(sclk[0]), ck_e(2, 7 + j), e0, a0, x0);
      acc(int'(fsync[0]), fs_e(0, 7 + j, 4, 1), e0, a0, x0);
      acc(int'(sclk[1]), ck_e(3, j), e1, a1, x1);
      acc(int'(fsync[1]), fs_e(0, j, 3, 1), e1, a1, x1);
    end
    chk(e0 == 0, "R10 ch0 writes ignored while enabled", a0, x0);
    chk(e1 == 0, "R10 ch1 writes accepted while ch0 enabled", a1, x1);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h3);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc(int'(sclk[0]), ck_e(2, i), e0, a0, x0);
      acc(int'(fsync[0]), fs_e(0, i, 4, 1), e0, a0, x0);
    end
    chk(e0 == 0, "R10 sync write was ignored", a0, x0);
    wr(3'd0, 32'h0);

    // R4 R5 R6 R7 R8: channel 0 sync, reference on source 2
    wr(3'd6, 32'h2);
    wr(3'd1, 32'h3);
    wr(3'd2, (5 << 16) | 4);
    wr(3'd3, (3 << 16) | 2);
    wr(3'd0, 32'h3);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 10; i++) begin
      ref_i[0] = ~ref_i[0];
      ref_i[1] = ~ref_i[1];
      @(negedge clk);
      acc(int'({sclk[0], fsync[0]}), 0, e0, a0, x0);
    end
    chk(e0 == 0, "R4 R6 idle without selected edge", a0, x0);
    ref_i[1:0] = 2'b00;
    e0 = 0; a0 = 0; x0 = 0; e1 = 0; a1 = 0; x1 = 0;
    for (int m = 0; m < 40; m++) begin
      ref_i[2] = ((m % 5) < 2);
      @(negedge clk);
      acc(int'(fsync[0]), (m < 3) ? 0 : fs_e(0, m, 5, 2), e0, a0, x0);
      acc(int'(sclk[0]), (m < 3) ? 0 : ck_e(4, m - 3), e1, a1, x1);
    end
    chk(e0 == 0, "R7 frame sync aligned to reference", a0, x0);
    chk(e1 == 0, "R5 R8 clock starts on edge, free runs", a1, x1);

    // R9: disable, re-arm, and disable on the very start edge
    ref_i[2] = 1'b0;
    wr(3'd0, 32'h0);
    chk(sclk == 0 && fsync == 0, "R9 disable low", {sclk, fsync}, 0);
    repeat (4) @(negedge clk);
    wr(3'd0, 32'h3);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      acc(int'({sclk[0], fsync[0]}), 0, e0, a0, x0);
    end
    chk(e0 == 0, "R9 re-armed waits for edge", a0, x0);
    ref_i[2] = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd0, 32'h0);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      acc(int'({sclk[0], fsync[0]}), 0, e0, a0, x0);
    end
    chk(e0 == 0, "R9 disable on start edge", a0, x0);
    wr(3'd0, 32'h3);
    e0 = 0; a0 = 0; x0 = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc(int'({sclk[0], fsync[0]}), 0, e0, a0, x0);
    end
    chk(e0 == 0, "R9 no start from held-high reference", a0, x0);
    ref_i[2] = 1'b0;
    repeat (3) @(negedge clk);
    ref_i[2] = 1'b1;
    e0 = 0; a0 = 0; x0 = 0;
    for (int m = 0; m < 13; m++) begin
      @(negedge clk);
      acc(int'(fsync[0]), (m < 3) ? 0 : fs_e(0, m, 5, 2), e0, a0, x0);
      acc(int'(sclk[0]), (m < 3) ? 0 : ck_e(4, m - 3), e0, a0, x0);
    end
    chk(e0 == 0, "R9 restart on fresh edge", a0, x0);
    wr(3'd0, 32'h0);
    ref_i = '0;

    // R4 R6 on channel 1: frame-sync synced to source 1, clock free
    wr(3'd6, 32'h0001_0000);
    wr(3'd1, 32'h0001_0000);
    wr(3'd4, (4 << 16) | 2);
    wr(3'd5, (3 << 16) | 1);
    wr(3'd0, 32'h0003_0000);
    k = 0;
    e0 = 0; a0 = 0; x0 = 0; e1 = 0; a1 = 0; x1 = 0;
    for (int i = 0; i < 8; i++) begin
      ref_i[0] = ~ref_i[0];
      ref_i[2] = ~ref_i[2];
      @(negedge clk);
      acc(int'(fsync[1]), 0, e0, a0, x0);
      acc(int'(sclk[1]), ck_e(2, k), e1, a1, x1);
      k++;
    end
    chk(e0 == 0, "R4 R6 ch1 frame sync waits", a0, x0);
    ref_i[0] = 1'b0; ref_i[2] = 1'b0;
    ref_i[1] = 1'b1;
    for (int m = 0; m < 12; m++) begin
      @(negedge clk);
      acc(int'(fsync[1]), (m < 3) ? 0 : fs_e(0, m, 4, 1), e0, a0, x0);
      acc(int'(sclk[1]), ck_e(2, k), e1, a1, x1);
      k++;
    end
    chk(e0 == 0, "R4 ch1 frame sync start", a0, x0);
    chk(e1 == 0, "R12 ch1 clock unsynced meanwhile", a1, x1);
    wr(3'd0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule